// File: doc/BRIEF.md
# Sector Write Command Sequencer

This block sits on the host side of a flash card controller. It turns one request into the complete series of byte writes on a microprocessor-style register port that store a run of sectors. The request carries a 28-bit starting block address, a sector count and a stream of 16-bit data words. The sequencer loads the address one byte at a time, then the sector count and the write command. Next it asserts a configuration reset bit and streams every data word as a pair of byte writes. It waits for a buffer-ready status at the start of each buffer-sized burst. At the end it clears the configuration reset and lock request bits.

The control register byte is never read back. A shadow copy keeps it, so each update to that byte keeps the bits it is not meant to change. A busy flag covers the whole transaction, and a one-cycle done pulse marks its end. The card controller deadlocks if a transfer stops short, so the sequencer always sends exactly sector count times 256 words.

Top module: `sector_wr_seq`

## Requirements
- R1: After reset, busy_o, done_o, bus_wr_o and word_take_o are all 0.
- R2: An accepted request first writes the block address low byte first: bits 7:0 to address 10h, bits 15:8 to 11h, bits 23:16 to 12h and bits 27:24 to 13h. The upper four bits of the 13h byte are 0.
- R3: The sector count is then written to address 14h, followed at once by the command value 04h to address 15h.
- R4: The write that follows the command goes to address 18h. Its data is the control shadow with bit 7 set. It comes before any data write.
- R5: Each data word is sent as bits 7:0 to address 40h, followed at once by bits 15:8 to address 41h. word_take_o is high in the cycle word_i is captured. Words go out in stream order.
- R6: Exactly count×256 words are written, in bursts of BUF_WORDS words. The first word of every burst goes out only after buf_rdy_i was sampled high.
- R7: The last write goes to address 18h. Its data is the shadow with bits 7 and 1 cleared and every other bit kept.
- R8: busy_o rises when a request is accepted and stays high through the final 18h write. It falls in the next cycle, in which done_o is high for exactly one cycle. bus_wr_o is high only while busy_o is high.
- R9: A start with a sector count of 0 is ignored, and so is a start while busy_o is high. Neither produces any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, sampled while idle |
| lba_i | input | 28 | Starting block address |
| count_i | input | CNT_W | Number of sectors |
| word_i | input | 16 | Current data word of the stream |
| buf_rdy_i | input | 1 | Card buffer ready status |
| word_take_o | output | 1 | High in the cycle word_i is consumed |
| bus_wr_o | output | 1 | Register port write strobe |
| bus_addr_o | output | 7 | Register port byte address |
| bus_wdata_o | output | 8 | Register port write data |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |

## Verification
The assertions assume three things about the inputs:
- the stream source holds word_i at the next word until word_take_o marks it consumed;
- the parameters make the sector size a multiple of the burst size;
- buf_rdy_i may change in any cycle but matters only at a burst boundary.

The stimulus keeps to these assumptions as follows. The bench derives each word from a running index that advances only once the high byte of the previous word has appeared on the bus. It drops buf_rdy_i for several cycles after the configuration reset write and after every completed burst. It also pokes start during a transfer and with a zero count, so that only well-formed requests produce writes.

// File: rtl/swseq_pkg.sv
package swseq_pkg;
   localparam int ADDR_W = 7;
   localparam int LBA_W  = 28;

   localparam logic [ADDR_W-1:0] A_LBA0 = 7'h10;
   localparam logic [ADDR_W-1:0] A_CNT  = 7'h14;
   localparam logic [ADDR_W-1:0] A_CMD  = 7'h15;
   localparam logic [ADDR_W-1:0] A_CTRL = 7'h18;
   localparam logic [ADDR_W-1:0] A_DLO  = 7'h40;
   localparam logic [ADDR_W-1:0] A_DHI  = 7'h41;

   localparam logic [7:0] CMD_WRITE = 8'h04;
   localparam int CFG_BIT  = 7;
   localparam int LOCK_BIT = 1;

   typedef enum logic [3:0] {
      ST_IDLE, ST_ADR, ST_CNT, ST_CMD, ST_CRS,
      ST_WBUF, ST_DLO, ST_DHI, ST_REL, ST_FIN
   } seq_state_t;
endpackage

// File: rtl/swseq_shadow.sv
module swseq_shadow
   import swseq_pkg::*;
#(
   parameter logic [7:0] INIT = 8'h0B
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       set_cfg,
   input  logic       release_all,
   output logic [7:0] q_set,
   output logic [7:0] q_rel
);
   logic [7:0] shadow_q;
   localparam logic [7:0] CFG_MASK  = 8'(1) << CFG_BIT;
   localparam logic [7:0] LOCK_MASK = 8'(1) << LOCK_BIT;

   assign q_set = shadow_q | CFG_MASK;
   assign q_rel = shadow_q & ~(CFG_MASK | LOCK_MASK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           shadow_q <= INIT;
      else if (set_cfg)     shadow_q <= q_set;
      else if (release_all) shadow_q <= q_rel;
   end

   AST_SHADOW_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_cfg && release_all));  // R4
   AST_REL_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      release_all |=> ((shadow_q & ~(CFG_MASK | LOCK_MASK)) ==
                       ($past(shadow_q) & ~(CFG_MASK | LOCK_MASK))));  // R7
endmodule

// File: rtl/swseq_cnt.sv
module swseq_cnt #(
   parameter int CNT_W        = 8,
   parameter int SECTOR_WORDS = 256,
   parameter int BUF_WORDS    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] count,
   input  logic             dec,
   output logic             last_buf,
   output logic             last_all
);
   localparam int  TOT_W   = CNT_W + $clog2(SECTOR_WORDS);
   localparam bit  IS_POW2 = (BUF_WORDS > 1) && ((BUF_WORDS & (BUF_WORDS - 1)) == 0);

   logic [TOT_W-1:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rem_q <= '0;
      else if (load) rem_q <= TOT_W'(count) * TOT_W'(SECTOR_WORDS);
      else if (dec)  rem_q <= rem_q - 1'b1;
   end

   assign last_all = (rem_q == TOT_W'(1));

   generate
      if (IS_POW2) begin : g_slice
         localparam int BUF_LOG = $clog2(BUF_WORDS);
         assign last_buf = (rem_q[BUF_LOG-1:0] == BUF_LOG'(1));
      end else begin : g_nested
         localparam int BC_W = $clog2(BUF_WORDS + 1);
         logic [BC_W-1:0] bcnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 bcnt_q <= BC_W'(BUF_WORDS);
            else if (load)              bcnt_q <= BC_W'(BUF_WORDS);
            else if (dec && last_buf)   bcnt_q <= BC_W'(BUF_WORDS);
            else if (dec)               bcnt_q <= bcnt_q - 1'b1;
         end
         assign last_buf = (bcnt_q == BC_W'(1));
      end
   endgenerate

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> (rem_q != '0));  // R6
   AST_LAST_ALL_IS_BUF_END: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && last_all) |-> last_buf);  // R6
endmodule

// File: rtl/sector_wr_seq.sv
module sector_wr_seq
   import swseq_pkg::*;
#(
   parameter int         CNT_W        = 8,
   parameter int         SECTOR_WORDS = 256,
   parameter int         BUF_WORDS    = 16,
   parameter logic [7:0] CTRL_INIT    = 8'h0B
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [27:0]       lba_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic [15:0]       word_i,
   input  logic              buf_rdy_i,
   output logic              word_take_o,
   output logic              bus_wr_o,
   output logic [6:0]        bus_addr_o,
   output logic [7:0]        bus_wdata_o,
   output logic              busy_o,
   output logic              done_o
);
   generate
      if (SECTOR_WORDS % BUF_WORDS != 0) begin : g_bad_buf
         $error("SECTOR_WORDS must be a multiple of BUF_WORDS");
      end
      if (CNT_W < 1 || BUF_WORDS < 1) begin : g_bad_width
         $error("CNT_W and BUF_WORDS must be at least 1");
      end
   endgenerate

   seq_state_t        st_q;
   logic [1:0]        idx_q;
   logic [LBA_W-1:0]  lba_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [7:0]        hi_q;
   logic [7:0]        sh_set, sh_rel;
   logic              last_buf, last_all;
   logic              accept, dec_w;

   assign accept      = (st_q == ST_IDLE) && start_i && (count_i != '0);
   assign dec_w       = (st_q == ST_DHI);
   assign word_take_o = (st_q == ST_DLO);

   swseq_cnt #(
      .CNT_W(CNT_W), .SECTOR_WORDS(SECTOR_WORDS), .BUF_WORDS(BUF_WORDS)
   ) cnt_i (
      .clk(clk), .rst_n(rst_n), .load(accept), .count(count_i),
      .dec(dec_w), .last_buf(last_buf), .last_all(last_all)
   );

   swseq_shadow #(.INIT(CTRL_INIT)) shadow_i (
      .clk(clk), .rst_n(rst_n),
      .set_cfg(st_q == ST_CRS), .release_all(st_q == ST_REL),
      .q_set(sh_set), .q_rel(sh_rel)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         idx_q       <= '0;
         lba_q       <= '0;
         cnt_q       <= '0;
         hi_q        <= '0;
         bus_wr_o    <= 1'b0;
         bus_addr_o  <= '0;
         bus_wdata_o <= '0;
         busy_o      <= 1'b0;
         done_o      <= 1'b0;
      end else begin
         bus_wr_o <= 1'b0;
         done_o   <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (accept) begin
               busy_o <= 1'b1;
               lba_q  <= lba_i;
               cnt_q  <= count_i;
               idx_q  <= '0;
               st_q   <= ST_ADR;
            end
            ST_ADR: begin
               bus_wr_o   <= 1'b1;
               bus_addr_o <= A_LBA0 + ADDR_W'(idx_q);
               unique case (idx_q)
                  2'd0: bus_wdata_o <= lba_q[7:0];
                  2'd1: bus_wdata_o <= lba_q[15:8];
                  2'd2: bus_wdata_o <= lba_q[23:16];
                  default: bus_wdata_o <= {4'h0, lba_q[27:24]};
               endcase
               idx_q <= idx_q + 1'b1;
               if (idx_q == 2'd3) st_q <= ST_CNT;
            end
            ST_CNT: begin
               bus_wr_o    <= 1'b1;
               bus_addr_o  <= A_CNT;
               bus_wdata_o <= 8'(cnt_q);
               st_q        <= ST_CMD;
            end
            ST_CMD: begin
               bus_wr_o    <= 1'b1;
               bus_addr_o  <= A_CMD;
               bus_wdata_o <= CMD_WRITE;
               st_q        <= ST_CRS;
            end
            ST_CRS: begin
               bus_wr_o    <= 1'b1;
               bus_addr_o  <= A_CTRL;
               bus_wdata_o <= sh_set;
               st_q        <= ST_WBUF;
            end
            ST_WBUF: if (buf_rdy_i) st_q <= ST_DLO;
            ST_DLO: begin
               bus_wr_o    <= 1'b1;
               bus_addr_o  <= A_DLO;
               bus_wdata_o <= word_i[7:0];
               hi_q        <= word_i[15:8];
               st_q        <= ST_DHI;
            end
            ST_DHI: begin
               bus_wr_o    <= 1'b1;
               bus_addr_o  <= A_DHI;
               bus_wdata_o <= hi_q;
               if (last_all)      st_q <= ST_REL;
               else if (last_buf) st_q <= ST_WBUF;
               else               st_q <= ST_DLO;
            end
            ST_REL: begin
               bus_wr_o    <= 1'b1;
               bus_addr_o  <= A_CTRL;
               bus_wdata_o <= sh_rel;
               st_q        <= ST_FIN;
            end
            ST_FIN: begin
               busy_o <= 1'b0;
               done_o <= 1'b1;
               st_q   <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   AST_LBA_TOP_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_o && bus_addr_o == 7'h13) |-> (bus_wdata_o[7:4] == 4'h0));  // R2
   AST_CMD_AFTER_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_o && bus_addr_o == A_CMD) |->
      ($past(bus_wr_o && bus_addr_o == A_CNT) && bus_wdata_o == CMD_WRITE));  // R3
   AST_CFG_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_o && bus_addr_o == A_CTRL && bus_wdata_o[CFG_BIT]) |->
      $past(bus_wr_o && bus_addr_o == A_CMD));  // R4
   AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_o && bus_addr_o == A_DHI) |-> $past(bus_wr_o && bus_addr_o == A_DLO));  // R5
   AST_BURST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DLO && $past(st_q) == ST_WBUF) |-> $past(buf_rdy_i));  // R6
   AST_DONE_AFTER_REL: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(bus_wr_o && bus_addr_o == A_CTRL && !bus_wdata_o[CFG_BIT]
                  && !bus_wdata_o[LOCK_BIT]) && !busy_o));  // R8
   AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr_o |-> busy_o);  // R8
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);  // R8
endmodule

// File: tb/sector_wr_seq_tb_top.sv
`timescale 1ns/1ps
module sector_wr_seq_tb_top;
   localparam int         CNT_W = 8;
   localparam int         SW    = 256;
   localparam int         BW    = 16;
   localparam logic [7:0] CINIT = 8'h0B;
   localparam int         HOLD  = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [27:0] lba_i = '0;
   logic [CNT_W-1:0] count_i = '0;
   logic [15:0] word_i;
   logic buf_rdy_i = 1'b0;
   logic word_take_o, bus_wr_o, busy_o, done_o;
   logic [6:0] bus_addr_o;
   logic [7:0] bus_wdata_o;

   always #2.5 clk = ~clk;

   sector_wr_seq #(.CNT_W(CNT_W), .SECTOR_WORDS(SW), .BUF_WORDS(BW), .CTRL_INIT(CINIT)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .lba_i(lba_i), .count_i(count_i),
      .word_i(word_i), .buf_rdy_i(buf_rdy_i), .word_take_o(word_take_o),
      .bus_wr_o(bus_wr_o), .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
      .busy_o(busy_o), .done_o(done_o)
   );

   int total = 0, bad = 0, cyc = 0;
   int word_idx = 0, takes = 0, bw_cnt = 0, hold = 0;
   logic rdy_prev = 1'b0, rel_prev = 1'b0;
   logic [7:0] shadow_m = CINIT;
   logic [14:0] expq[$];

   function automatic logic [15:0] wfun(int k);
      logic [7:0] lo;
      lo = 8'(k) ^ 8'h5A;
      return {8'(k >> 8) + 8'(k), lo};
   endfunction

   assign word_i = wfun(word_idx);

   function automatic string req_of(logic [6:0] a);
      if (a >= 7'h10 && a <= 7'h13) return "R2";
      if (a == 7'h14 || a == 7'h15) return "R3";
      if (a == 7'h40 || a == 7'h41) return "R5";
      return "R4/R7";
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor, buffer responder and stream source
   always @(negedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         bad++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
      if (rel_prev) begin
         check("R8 done after release", {30'b0, done_o, busy_o}, 32'b10);
      end else if (rst_n) begin
         check("R8 no stray done", {31'b0, done_o}, 32'b0);
      end
      rel_prev = 1'b0;
      if (word_take_o) takes++;
      if (bus_wr_o) begin
         check("R8 write only while busy", {31'b0, busy_o}, 32'b1);
         if (expq.size() == 0) begin
            check("R9 unexpected write", {17'b0, bus_addr_o, bus_wdata_o}, 32'hFFFF);
         end else begin
            logic [14:0] e;
            e = expq.pop_front();
            check(req_of(e[14:8]), {17'b0, bus_addr_o, bus_wdata_o}, {17'b0, e});
         end
         if (bus_addr_o == 7'h40 && bw_cnt == 0)
            check("R6 burst waits ready", {31'b0, rdy_prev}, 32'b1);
         if (bus_addr_o == 7'h41) begin
            word_idx++;
            bw_cnt++;
            if (bw_cnt == BW) begin
               bw_cnt = 0;
               buf_rdy_i = 1'b0;
               hold = HOLD;
            end
         end
         if (bus_addr_o == 7'h18 && bus_wdata_o[7]) begin
            buf_rdy_i = 1'b0;
            hold = HOLD;
         end
         if (bus_addr_o == 7'h18 && !bus_wdata_o[7]) rel_prev = 1'b1;
      end
      rdy_prev = buf_rdy_i;
      if (hold > 0) begin
         hold--;
         if (hold == 0) buf_rdy_i = 1'b1;
      end
   end

   task automatic push(logic [6:0] a, logic [7:0] d);
      expq.push_back({a, d});
   endtask

   task automatic run_cmd(logic [27:0] lba, logic [CNT_W-1:0] cnt, bit poke);
      int base, t0, n;
      base = word_idx;
      t0 = takes;
      push(7'h10, lba[7:0]);
      push(7'h11, lba[15:8]);
      push(7'h12, lba[23:16]);
      push(7'h13, {4'h0, lba[27:24]});
      push(7'h14, 8'(cnt));
      push(7'h15, 8'h04);
      shadow_m = shadow_m | 8'h80;
      push(7'h18, shadow_m);
      for (int w = 0; w < int'(cnt) * SW; w++) begin
         logic [15:0] v;
         v = wfun(base + w);
         push(7'h40, v[7:0]);
         push(7'h41, v[15:8]);
      end
      shadow_m = shadow_m & ~8'h82;
      push(7'h18, shadow_m);
      @(negedge clk);
      start_i = 1'b1; lba_i = lba; count_i = cnt;
      @(negedge clk);
      start_i = 1'b0;
      check("R8 busy after accept", {31'b0, busy_o}, 32'b1);
      if (poke) begin
         repeat (40) @(negedge clk);
         start_i = 1'b1; lba_i = 28'h1234567; count_i = 8'd2;  // R9 start while busy
         @(negedge clk);
         start_i = 1'b0;
      end
      n = 0;
      while (!done_o && n < 40000) begin
         @(negedge clk);
         n++;
      end
      check("R8 done seen", {31'b0, done_o}, 32'b1);
      check("R6 all writes issued", expq.size(), 0);
      check("R5 word takes", takes - t0, int'(cnt) * SW);
      check("R6 words streamed", word_idx - base, int'(cnt) * SW);
      @(negedge clk);
      check("R8 done single cycle", {30'b0, done_o, busy_o}, 32'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset outputs", {28'b0, busy_o, done_o, bus_wr_o, word_take_o}, 32'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after reset", {30'b0, busy_o, bus_wr_o}, 32'b0);

      run_cmd(28'hABCDEF1, 8'd1, 1'b0);
      run_cmd(28'h0000000, 8'd3, 1'b1);

      // R9: zero count is ignored
      @(negedge clk);
      start_i = 1'b1; lba_i = 28'h7654321; count_i = '0;
      @(negedge clk);
      start_i = 1'b0;
      repeat (20) @(negedge clk);
      check("R9 zero count keeps idle", {31'b0, busy_o}, 32'b0);
      check("R9 no queued writes", expq.size(), 0);

      run_cmd(28'hFFFFFFF, 8'd2, 1'b0);
      repeat (5) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule